// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block drives a 5 V NOR flash built from two byte-wide lanes that share address and output-enable lines but have their own chip select and write enable. A host asks for one operation at a time: a plain read, a byte program, an erase of one of eight equal sectors, or an erase of the whole device. The block writes the unlock and command bytes the flash expects, holding each write-enable pulse and the gap between pulses for a set number of clock cycles. It then reads the target lane again and again until data bit 7 shows that the flash has finished its internal operation, or until a timeout set per operation runs out.

The controller is a single state machine. IDLE accepts `start` and goes to PRD for a read, or to WSET for any write-based operation. WSET presents address and data with chip select low. WLO holds write enable low for `WE_LOW_CYC` cycles. WHI keeps address and data on the bus with both strobes high for `WE_HIGH_CYC` cycles. From WHI the machine returns to WSET for the next command step, or goes to PRD once the last step is written. PRD holds chip select and output enable low for `RD_CYC` cycles and captures the lane byte. PEV evaluates that byte. It goes to DONE on a match or when the timeout has expired, and back to PRD otherwise. A read always goes from PEV to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `fcmd_seq`

## Requirements
- R1: With `op`=01 (program), exactly four bus writes occur on the selected lane, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (`addr`, `wdata`).
- R2: With `op`=10 (sector erase), exactly six writes occur: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then 30h to the sector base. The sector base is `addr` with bits 15..0 cleared, so bits 18..16 select one of eight 64 KB sectors.
- R3: With `op`=11 (chip erase), the same first five writes occur, and the sixth write is 10h to 5555h.
- R4: `lane`=0 uses bit 0 of `mem_cs_n` and `mem_we_n` and reads `mem_rd[7:0]`. `lane`=1 uses bit 1 and reads `mem_rd[15:8]`. The unselected lane's chip select and write enable stay high for the whole operation.
- R5: Each write-enable low pulse lasts at least `WE_LOW_CYC` cycles, and write enable stays high for at least `WE_HIGH_CYC` cycles between pulses. Address and write data stay stable while write enable is low and in the cycle it rises.
- R6: After a program, polling completes when bit 7 of the lane byte equals `wdata[7]`. `done` then pulses with `error`=0, and `rdata` holds the byte read.
- R7: After either erase, polling completes when bit 7 of the lane byte reads 1. `done` then pulses with `error`=0, and `rdata` holds the byte read.
- R8: If polling has not completed within the timeout for the operation, counted in cycles from the first poll read, `done` pulses with `error`=1. `error` is never high without `done`.
- R9: With `op`=00 (read), one read cycle with chip select and `mem_oe_n` low for `RD_CYC` cycles returns the lane byte on `rdata` with `error`=0, and no write strobe falls.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after `start` is accepted through the `done` cycle. A `start` while busy is ignored.
- R11: After reset, all chip selects, write enables and `mem_oe_n` are high, `mem_wd_en` is low, and `busy`, `done` and `error` are 0.
- R12: `mem_oe_n` is never low while `mem_wd_en` is high or any write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted in IDLE |
| op | input | 2 | 00 read, 01 program, 10 sector erase, 11 chip erase |
| addr | input | AW | Target byte address within a lane |
| wdata | input | 8 | Byte to program |
| lane | input | 1 | Lane select (0 low byte, 1 high byte) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with done |
| rdata | output | 8 | Last byte read from the selected lane |
| mem_addr | output | AW | Flash address bus |
| mem_wd | output | 8 | Byte driven toward the flash |
| mem_wd_en | output | 1 | Output enable for `mem_wd` |
| mem_rd | input | 16 | Data from both flash lanes |
| mem_cs_n | output | 2 | Per-lane chip select, active low |
| mem_we_n | output | 2 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |

## Verification
The in-RTL assertions check some properties on every cycle. They check that the idle lane stays quiet, that the read output enable never overlaps a write drive, that each write-enable pulse is long enough with address and data held across it, that `done` is a single-cycle pulse with `error` only beside it, and that a read request never lowers a write strobe. Only the bench scenarios can show the rest. That covers the exact order of unlock and command bytes, the sector base address, the completion rule on bit 7 for program versus erase, the length of the timeout window, and the lane byte returned on `rdata`.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SERASE = 2'b10,
        OP_CERASE = 2'b11
    } fop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSET,
        S_WLO,
        S_WHI,
        S_PRD,
        S_PEV,
        S_DONE
    } fst_e;

    // unlock key addresses and bytes
    localparam logic [15:0] KEY_A1 = 16'h5555;
    localparam logic [15:0] KEY_A2 = 16'h2AAA;
    localparam logic [7:0]  KEY_D1 = 8'hAA;
    localparam logic [7:0]  KEY_D2 = 8'h55;

    // command bytes
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;

endpackage

// File: rtl/fcmd_steps.sv
module fcmd_steps
    import fcmd_pkg::*;
#(
    parameter int AW        = 19,
    parameter int SECT_BITS = 3
) (
    input  fop_e            op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [7:0]      tgt_data,
    output logic [AW-1:0]   s_addr,
    output logic [7:0]      s_data,
    output logic            s_last
);
    localparam int OFS_W = AW - SECT_BITS;

    logic [AW-1:0] sect_base;
    assign sect_base = {tgt_addr[AW-1 -: SECT_BITS], {OFS_W{1'b0}}};

    always_comb begin
        s_addr = AW'(KEY_A1);
        s_data = KEY_D1;
        s_last = 1'b0;
        case (step)
            3'd0, 3'd3: begin
                s_addr = AW'(KEY_A1);
                s_data = KEY_D1;
            end
            3'd1, 3'd4: begin
                s_addr = AW'(KEY_A2);
                s_data = KEY_D2;
            end
            3'd2: begin
                s_addr = AW'(KEY_A1);
                s_data = (op == OP_PROG) ? CMD_PROG : CMD_ERASE;
            end
            default: begin
                s_last = 1'b1;
                if (op == OP_SERASE) begin
                    s_addr = sect_base;
                    s_data = CMD_SECT;
                end else begin
                    s_addr = AW'(KEY_A1);
                    s_data = CMD_CHIP;
                end
            end
        endcase
        // program ends after the fourth write, to the target itself
        if (op == OP_PROG && step == 3'd3) begin
            s_addr = tgt_addr;
            s_data = tgt_data;
            s_last = 1'b1;
        end
    end

endmodule

// File: rtl/fcmd_down.sv
module fcmd_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int AW                  = 19,
    parameter int SECT_BITS           = 3,
    parameter int WE_LOW_CYC          = 12,
    parameter int WE_HIGH_CYC         = 5,
    parameter int RD_CYC              = 23,
    parameter longint unsigned PROG_TO   = 64'd75_000,
    parameter longint unsigned SERASE_TO = 64'd3_750_000_000,
    parameter longint unsigned CERASE_TO = 64'd16_000_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          lane,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [7:0]    rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wd,
    output logic          mem_wd_en,
    input  logic [15:0]   mem_rd,
    output logic [1:0]    mem_cs_n,
    output logic [1:0]    mem_we_n,
    output logic          mem_oe_n
);
    localparam int SMAX = (WE_LOW_CYC > WE_HIGH_CYC)
                        ? ((WE_LOW_CYC > RD_CYC) ? WE_LOW_CYC : RD_CYC)
                        : ((WE_HIGH_CYC > RD_CYC) ? WE_HIGH_CYC : RD_CYC);
    localparam int SW = $clog2(SMAX + 1);
    localparam longint unsigned TO_MAX = (PROG_TO > SERASE_TO)
                        ? ((PROG_TO > CERASE_TO) ? PROG_TO : CERASE_TO)
                        : ((SERASE_TO > CERASE_TO) ? SERASE_TO : CERASE_TO);
    localparam int TW = $clog2(TO_MAX + 1);

    fst_e          state_q, state_d;
    fop_e          op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          lane_q;
    logic [2:0]    step_q;
    logic          err_q;
    logic [7:0]    rd_q;

    logic          accept, step_inc, capture, set_err;
    logic          st_load, st_zero, to_load, to_en, to_zero;
    logic [SW-1:0] st_val;
    logic [TW-1:0] to_val;
    logic [AW-1:0] s_addr;
    logic [7:0]    s_data;
    logic          s_last;
    logic          poll_ok;

    fcmd_steps #(.AW(AW), .SECT_BITS(SECT_BITS)) u_steps (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .s_addr   (s_addr),
        .s_data   (s_data),
        .s_last   (s_last)
    );

    fcmd_down #(.W(SW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .en       (1'b1),
        .load_val (st_val),
        .zero     (st_zero)
    );

    fcmd_down #(.W(TW)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (to_load),
        .en       (to_en),
        .load_val (to_val),
        .zero     (to_zero)
    );

    always_comb begin
        case (op_q)
            OP_PROG:   to_val = TW'(PROG_TO);
            OP_SERASE: to_val = TW'(SERASE_TO);
            default:   to_val = TW'(CERASE_TO);
        endcase
    end

    // program waits for the true bit 7; erased cells read back as ones
    assign poll_ok = (op_q == OP_PROG) ? (rd_q[7] == data_q[7]) : rd_q[7];
    assign to_en   = (state_q == S_PRD) || (state_q == S_PEV);

    // next-state and control decode
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        step_inc = 1'b0;
        capture  = 1'b0;
        set_err  = 1'b0;
        st_load  = 1'b0;
        st_val   = '0;
        to_load  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    if (fop_e'(op) == OP_READ) begin
                        state_d = S_PRD;
                        st_load = 1'b1;
                        st_val  = SW'(RD_CYC - 1);
                    end else begin
                        state_d = S_WSET;
                    end
                end
            end
            S_WSET: begin
                state_d = S_WLO;
                st_load = 1'b1;
                st_val  = SW'(WE_LOW_CYC - 1);
            end
            S_WLO: begin
                if (st_zero) begin
                    state_d = S_WHI;
                    st_load = 1'b1;
                    st_val  = SW'(WE_HIGH_CYC - 1);
                end
            end
            S_WHI: begin
                if (st_zero) begin
                    if (s_last) begin
                        state_d = S_PRD;
                        st_load = 1'b1;
                        st_val  = SW'(RD_CYC - 1);
                        to_load = 1'b1;
                    end else begin
                        state_d  = S_WSET;
                        step_inc = 1'b1;
                    end
                end
            end
            S_PRD: begin
                if (st_zero) begin
                    state_d = S_PEV;
                    capture = 1'b1;
                end
            end
            S_PEV: begin
                if (op_q == OP_READ || poll_ok) begin
                    state_d = S_DONE;
                end else if (to_zero) begin
                    state_d = S_DONE;
                    set_err = 1'b1;
                end else begin
                    state_d = S_PRD;
                    st_load = 1'b1;
                    st_val  = SW'(RD_CYC - 1);
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            data_q  <= '0;
            lane_q  <= 1'b0;
            step_q  <= '0;
            err_q   <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= fop_e'(op);
                addr_q <= addr;
                data_q <= wdata;
                lane_q <= lane;
                step_q <= '0;
                err_q  <= 1'b0;
            end
            if (step_inc) step_q <= step_q + 3'd1;
            if (set_err)  err_q  <= 1'b1;
            if (capture)  rd_q   <= lane_q ? mem_rd[15:8] : mem_rd[7:0];
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_cs_n  = 2'b11;
        mem_we_n  = 2'b11;
        mem_oe_n  = 1'b1;
        mem_wd_en = 1'b0;
        mem_addr  = addr_q;
        mem_wd    = s_data;
        unique case (state_q)
            S_WSET: begin
                mem_addr         = s_addr;
                mem_cs_n[lane_q] = 1'b0;
                mem_wd_en        = 1'b1;
            end
            S_WLO: begin
                mem_addr         = s_addr;
                mem_cs_n[lane_q] = 1'b0;
                mem_we_n[lane_q] = 1'b0;
                mem_wd_en        = 1'b1;
            end
            S_WHI: begin
                mem_addr  = s_addr;
                mem_wd_en = 1'b1;
            end
            S_PRD: begin
                mem_cs_n[lane_q] = 1'b0;
                mem_oe_n         = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy  = (state_q != S_IDLE);
    assign done  = (state_q == S_DONE);
    assign error = done && err_q;
    assign rdata = rd_q;

    // ---------------- assertions ----------------
    logic [SW:0] we_lo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  we_lo_run <= '0;
        else if (mem_we_n != 2'b11)  we_lo_run <= (we_lo_run == '1) ? we_lo_run : we_lo_run + 1'b1;
        else                         we_lo_run <= '0;
    end

    p_lane_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_cs_n[!lane_q] && mem_we_n[!lane_q]));

    p_no_contention_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_wd_en && (&mem_we_n)));

    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&mem_we_n) |-> (we_lo_run >= (SW+1)'(WE_LOW_CYC)));

    p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_n != 2'b11) && $past(mem_we_n != 2'b11)) |-> ($stable(mem_addr) && $stable(mem_wd)));

    p_we_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&mem_we_n) |-> ($stable(mem_addr) && $stable(mem_wd) && mem_wd_en));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    p_read_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == OP_READ) |-> (&mem_we_n));

endmodule

// File: tb/fcmd_seq_test.sv
module fcmd_seq_test;
    localparam int AW  = 19;
    localparam int WLO = 12;
    localparam int WHI = 5;
    localparam int RDC = 23;
    localparam longint unsigned PTO = 300;
    localparam longint unsigned STO = 500;
    localparam longint unsigned CTO = 700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          lane = 1'b0;
    logic          busy, done, error;
    logic [7:0]    rdata;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wd;
    logic          mem_wd_en;
    logic [15:0]   mem_rd;
    logic [1:0]    mem_cs_n, mem_we_n;
    logic          mem_oe_n;

    fcmd_seq #(
        .AW(AW), .SECT_BITS(3), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI), .RD_CYC(RDC),
        .PROG_TO(PTO), .SERASE_TO(STO), .CERASE_TO(CTO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .lane(lane), .busy(busy), .done(done), .error(error), .rdata(rdata),
        .mem_addr(mem_addr), .mem_wd(mem_wd), .mem_wd_en(mem_wd_en), .mem_rd(mem_rd),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // flash model: busy until busy_len cycles after the arm_at-th write
    logic [7:0] mdl_val = 8'h00;
    int         arm_at = 0;
    int         busy_len = 0;
    int         clr_req = 0;
    int         clr_seen = 0;
    int         wr_n, since_arm, run_lo, min_lo, min_hi, done_n;
    longint     cyc = 0;
    longint     last_rise;
    bit         other_hit;
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];
    logic [1:0]    prev_we = 2'b11;
    logic          mdl_busy;
    logic [7:0]    cur_b;

    assign mdl_busy = (wr_n < arm_at) || (since_arm < busy_len);
    assign cur_b    = mdl_busy ? ~mdl_val : mdl_val;
    assign mem_rd   = lane ? {cur_b, 8'h5A} : {8'h5A, cur_b};

    always @(negedge clk) begin
        cyc++;
        if (clr_req != clr_seen) begin
            clr_seen  = clr_req;
            wr_n      = 0;
            since_arm = 0;
            run_lo    = 0;
            min_lo    = 1000;
            min_hi    = 1000;
            done_n    = 0;
            last_rise = -1;
            other_hit = 1'b0;
        end
        if (prev_we != 2'b11 && mem_we_n == 2'b11) begin
            if (wr_n < 8) begin
                wa[wr_n] = mem_addr;
                wd[wr_n] = mem_wd;
            end
            wr_n++;
            if (run_lo < min_lo) min_lo = run_lo;
            run_lo    = 0;
            last_rise = cyc;
        end
        if (prev_we == 2'b11 && mem_we_n != 2'b11 && last_rise >= 0) begin
            if (int'(cyc - last_rise) < min_hi) min_hi = int'(cyc - last_rise);
        end
        if (mem_we_n != 2'b11) run_lo++;
        if (busy && (!mem_cs_n[!lane] || !mem_we_n[!lane])) other_hit = 1'b1;
        if (done) done_n++;
        if (wr_n >= arm_at && since_arm < busy_len) since_arm++;
        prev_we = mem_we_n;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void exp_step(input logic [1:0] o, input int i,
                                     input logic [AW-1:0] a, input logic [7:0] d,
                                     output logic [AW-1:0] ea, output logic [7:0] ed);
        case (i)
            0, 3: begin ea = 19'h05555; ed = 8'hAA; end
            1, 4: begin ea = 19'h02AAA; ed = 8'h55; end
            2:    begin ea = 19'h05555; ed = (o == 2'b01) ? 8'hA0 : 8'h80; end
            default: begin
                if (o == 2'b10) begin ea = {a[18:16], 16'h0000}; ed = 8'h30; end
                else begin ea = 19'h05555; ed = 8'h10; end
            end
        endcase
        if (o == 2'b01 && i == 3) begin ea = a; ed = d; end
    endfunction

    logic   got_err;
    logic [7:0] got_rd;
    longint got_elapsed;
    bit     got_done;

    task automatic run_op(input logic [1:0] o, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic ln, input logic [7:0] val, input int blen,
                          input bit second_start, input string req);
        clr_req++;
        mdl_val  = val;
        busy_len = blen;
        arm_at   = (o == 2'b00) ? 0 : ((o == 2'b01) ? 4 : 6);
        lane     = ln;
        @(negedge clk);
        @(negedge clk);
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after start", busy, 1);
        if (second_start) begin
            @(negedge clk);
            @(negedge clk);
            op = 2'b00; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            op = o;
        end
        got_done = 1'b0;
        for (int k = 0; k < 40000 && !got_done; k++) begin
            @(posedge clk);
            #1;
            if (done) begin
                got_done    = 1'b1;
                got_err     = error;
                got_rd      = rdata;
                got_elapsed = cyc - last_rise;
            end
        end
        chk(got_done, req, "done seen (watchdog)", got_done, 1);
        repeat (3) @(posedge clk);
        #1;
        chk(done_n == 1, "R10", "done pulse count", done_n, 1);
        chk(!busy, "R10", "busy after done", busy, 0);
        chk(!other_hit, "R4", "unselected lane strobe", other_hit, 0);
    endtask

    task automatic check_writes(input logic [1:0] o, input logic [AW-1:0] a,
                                input logic [7:0] d, input int n, input string req);
        logic [AW-1:0] ea;
        logic [7:0]    ed;
        chk(wr_n == n, req, "write count", wr_n, n);
        for (int i = 0; i < n && i < 8; i++) begin
            exp_step(o, i, a, d, ea, ed);
            chk(wa[i] == ea, req, $sformatf("write %0d address", i), wa[i], ea);
            chk(wd[i] == ed, req, $sformatf("write %0d data", i), wd[i], ed);
        end
        chk(min_lo >= WLO, "R5", "shortest write-enable low", min_lo, WLO);
        chk(min_hi >= WHI, "R5", "shortest write-enable high gap", min_hi, WHI);
    endtask

    task automatic t_reset();
        #1;
        chk(mem_cs_n == 2'b11, "R11", "cs_n in reset", mem_cs_n, 3);
        chk(mem_we_n == 2'b11, "R11", "we_n in reset", mem_we_n, 3);
        chk(mem_oe_n == 1'b1, "R11", "oe_n in reset", mem_oe_n, 1);
        chk(mem_wd_en == 1'b0, "R11", "wd_en in reset", mem_wd_en, 0);
        chk(!busy && !done && !error, "R11", "status in reset", {busy, done, error}, 0);
    endtask

    task automatic t_program_lane0();
        run_op(2'b01, 19'h12345, 8'h3C, 1'b0, 8'h3C, 60, 1'b0, "R6");
        check_writes(2'b01, 19'h12345, 8'h3C, 4, "R1");
        chk(got_err == 1'b0, "R6", "program error", got_err, 0);
        chk(got_rd == 8'h3C, "R6", "program readback", got_rd, 8'h3C);
    endtask

    task automatic t_program_lane1_restart();
        run_op(2'b01, 19'h7FFFF, 8'hC5, 1'b1, 8'hC5, 30, 1'b1, "R10");
        check_writes(2'b01, 19'h7FFFF, 8'hC5, 4, "R1");
        chk(got_err == 1'b0, "R6", "program lane1 error", got_err, 0);
        chk(got_rd == 8'hC5, "R6", "program lane1 readback", got_rd, 8'hC5);
    endtask

    task automatic t_sector_erase();
        run_op(2'b10, 19'h51234, 8'h00, 1'b1, 8'hFF, 80, 1'b0, "R7");
        check_writes(2'b10, 19'h51234, 8'h00, 6, "R2");
        chk(got_err == 1'b0, "R7", "sector erase error", got_err, 0);
        chk(got_rd == 8'hFF, "R7", "sector erase readback", got_rd, 8'hFF);
    endtask

    task automatic t_chip_erase();
        run_op(2'b11, 19'h3ABCD, 8'h00, 1'b0, 8'hFF, 120, 1'b0, "R7");
        check_writes(2'b11, 19'h3ABCD, 8'h00, 6, "R3");
        chk(got_err == 1'b0, "R7", "chip erase error", got_err, 0);
        chk(got_rd == 8'hFF, "R7", "chip erase readback", got_rd, 8'hFF);
    endtask

    task automatic t_program_timeout();
        run_op(2'b01, 19'h00010, 8'h81, 1'b0, 8'h81, 1_000_000, 1'b0, "R8");
        chk(got_err == 1'b1, "R8", "timeout error", got_err, 1);
        chk(got_elapsed >= longint'(PTO) && got_elapsed <= longint'(PTO) + WHI + RDC + 4,
            "R8", "timeout window", got_elapsed, PTO);
    endtask

    task automatic t_read();
        run_op(2'b00, 19'h4567, 8'h00, 1'b1, 8'h96, 0, 1'b0, "R9");
        chk(wr_n == 0, "R9", "writes during read", wr_n, 0);
        chk(got_err == 1'b0, "R9", "read error", got_err, 0);
        chk(got_rd == 8'h96, "R9", "read data", got_rd, 8'h96);
    endtask

    initial begin
        clr_req = 1;
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_program_lane0();
        t_program_lane1_restart();
        t_sector_erase();
        t_chip_erase();
        t_program_timeout();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule